// File: doc/BRIEF.md
# Dual-Channel Serial Controller Shared Interrupt and Port Registers

This block holds the register logic that both channels of a two-channel serial controller share. It takes each channel's receive-ready and transmit-ready levels and places them in an interrupt status byte. Channel B's bits are channel A's bits moved up by four positions. The block ANDs that byte with a programmable enable mask and drives one active-low, level-sensitive interrupt request from the result. Status bits are live copies of the channel flags. Software never acknowledges them: a bit drops when its channel condition drops.

The same address returns the status on a read and loads the enable mask on a write. The block also has an 8-bit general-purpose output port. Software changes it only through a bit-set write address and a bit-clear write address, and the pins drive the complement of the port register. An 8-bit input port is read through a two-flop synchronizer. Two plain stored bytes, an auxiliary control byte and an output-port configuration byte, are written at their own addresses and presented to the rest of the controller.

The bus is a single-cycle write strobe with address and data. Read data is a combinational decode of the address and has no side effects.

Top module: `duart_shared_regs`

## Requirements
- R1: After reset the enable mask and the output port register are zero. irq_n is 1, op_pins_n is 8'hFF, aux_ctrl and op_cfg are 0.
- R2: A read at address 0x14 returns the status byte. Bit 0 is channel A transmit ready, bit 1 is channel A receive ready, bit 4 is channel B transmit ready and bit 5 is channel B receive ready. Each bit reflects the flag sampled at the previous clock edge.
- R3: A write at 0x14 loads the enable mask, which has the same bit layout as the status byte. The write does not change what a read of 0x14 returns.
- R4: irq_n is 0 exactly when (status AND mask) is nonzero. It follows a flag or mask change by one clock edge.
- R5: A status bit clears on the edge after its channel flag clears. Reading the status does not clear any bit.
- R6: A write at 0x38 sets every output port bit that is 1 in the data and leaves the other bits alone.
- R7: A write at 0x3C clears every output port bit that is 1 in the data and leaves the other bits alone.
- R8: op_pins_n is the bitwise complement of the output port register at all times.
- R9: A read at 0x34 returns ip_pins as sampled two clock edges earlier, with no inversion.
- R10: A write at 0x34 stores op_cfg and a write at 0x10 stores aux_ctrl. Neither write changes the output pins or the mask.
- R11: Status bits 2, 3, 6 and 7 read as 0. Reads at addresses other than 0x14 and 0x34 return 0.
- R12: Writes to unmapped addresses change no mask, output port, aux_ctrl or op_cfg state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ch_txrdy | input | 2 | Per-channel transmit-ready level, index 0 = channel A |
| ch_rxrdy | input | 2 | Per-channel receive-ready level, index 0 = channel A |
| irq_n | output | 1 | Active-low level interrupt request |
| op_pins_n | output | 8 | Output port pins, complement of the port register |
| ip_pins | input | 8 | Asynchronous input port pins |
| aux_ctrl | output | 8 | Stored auxiliary control byte |
| op_cfg | output | 8 | Stored output-port configuration byte |

## Verification
The block is nearly all visible state, so a corrupted mask or status byte shows on irq_n one edge after the flag or mask that exposes it. A bit of the port register that is wrong, or that changes without a matching write, shows on op_pins_n at once. Status placement errors, such as a channel shifted to the wrong nibble or transmit and receive swapped, show on the first read of 0x14. The synchronizer depth shows as the input value arriving a cycle early or late at 0x34. Decode faults that let a write at one address reach another register are caught by checking every output after writes to the neighbouring addresses.

// File: rtl/duart_common_pkg.sv
package duart_common_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 6;
  localparam int NUM_CH    = 2;
  localparam int CH_STRIDE = 4;
  localparam int TX_POS    = 0;
  localparam int RX_POS    = 1;

  // Common register offsets
  localparam logic [ADDR_W-1:0] OFS_AUX    = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_INT    = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_INPCFG = 6'h34;
  localparam logic [ADDR_W-1:0] OFS_OPSET  = 6'h38;
  localparam logic [ADDR_W-1:0] OFS_OPCLR  = 6'h3C;

  typedef struct packed {
    logic aux;
    logic mask;
    logic cfg;
    logic opset;
    logic opclr;
  } wr_sel_t;
endpackage

// File: rtl/duart_rst_sync.sv
module duart_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/duart_irq_ctrl.sv
module duart_irq_ctrl #(
  parameter int DATA_W    = 8,
  parameter int NUM_CH    = 2,
  parameter int CH_STRIDE = 4,
  parameter int TX_POS    = 0,
  parameter int RX_POS    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] txrdy,
  input  logic [NUM_CH-1:0] rxrdy,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wdata,
  output logic [DATA_W-1:0] status,
  output logic              irq_n
);
  localparam int USED_W = NUM_CH * CH_STRIDE;

  function automatic logic [DATA_W-1:0] defined_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[c*CH_STRIDE + TX_POS] = 1'b1;
      m[c*CH_STRIDE + RX_POS] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] DEF_BITS = defined_bits();

  logic [DATA_W-1:0] stat_d, stat_q;
  logic [DATA_W-1:0] mask_d, mask_q;
  logic              armed_q;

  initial begin
    if (USED_W > DATA_W) $error("channel bits exceed register width");
  end

  always_comb begin
    stat_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      stat_d[c*CH_STRIDE + TX_POS] = txrdy[c];
      stat_d[c*CH_STRIDE + RX_POS] = rxrdy[c];
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = mask_wdata & DEF_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      mask_q  <= mask_d;
      armed_q <= 1'b1;
    end
  end

  assign status = stat_q;
  assign irq_n  = ~|(stat_q & mask_q);

  // Status bits track the channel flags one edge later
  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chk
    a_r2_tx_follow: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (stat_q[gc*CH_STRIDE + TX_POS] == $past(txrdy[gc])));
    a_r5_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (stat_q[gc*CH_STRIDE + RX_POS] == $past(rxrdy[gc])));
  end

  // A mask write of zero silences the request on the next edge
  a_r4_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && (mask_wdata == '0)) |=> irq_n);

  // Reserved status positions never rise
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ((status & ~DEF_BITS) == '0));
endmodule

// File: rtl/duart_io_port.sv
module duart_io_port #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] pins_n,
  input  logic [PORT_W-1:0] ip_pins,
  output logic [PORT_W-1:0] ip_sync
);
  logic [PORT_W-1:0] op_d, op_q;
  logic [PORT_W-1:0] meta_q, sync_q;

  always_comb begin
    op_d = op_q;
    if (set_we)      op_d = op_q | wdata;
    else if (clr_we) op_d = op_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      op_q   <= op_d;
      meta_q <= ip_pins;
      sync_q <= meta_q;
    end
  end

  assign pins_n  = ~op_q;
  assign ip_sync = sync_q;

  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((~pins_n & $past(wdata)) == $past(wdata)));
  a_r7_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((~pins_n & $past(wdata)) == '0));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(pins_n));
endmodule

// File: rtl/duart_shared_regs.sv
module duart_shared_regs
  import duart_common_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_NUM_CH = NUM_CH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  input  logic [P_NUM_CH-1:0] ch_txrdy,
  input  logic [P_NUM_CH-1:0] ch_rxrdy,
  output logic                irq_n,
  output logic [P_DATA_W-1:0] op_pins_n,
  input  logic [P_DATA_W-1:0] ip_pins,
  output logic [P_DATA_W-1:0] aux_ctrl,
  output logic [P_DATA_W-1:0] op_cfg
);
  logic                rst_sync_n;
  wr_sel_t             wsel;
  logic [P_DATA_W-1:0] status, ip_sync;
  logic [P_DATA_W-1:0] aux_d, aux_q, cfg_d, cfg_q;

  duart_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wsel       = '0;
    wsel.aux   = bus_wr && (bus_addr == OFS_AUX);
    wsel.mask  = bus_wr && (bus_addr == OFS_INT);
    wsel.cfg   = bus_wr && (bus_addr == OFS_INPCFG);
    wsel.opset = bus_wr && (bus_addr == OFS_OPSET);
    wsel.opclr = bus_wr && (bus_addr == OFS_OPCLR);
  end

  duart_irq_ctrl #(
    .DATA_W    (P_DATA_W),
    .NUM_CH    (P_NUM_CH),
    .CH_STRIDE (CH_STRIDE),
    .TX_POS    (TX_POS),
    .RX_POS    (RX_POS)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .txrdy      (ch_txrdy),
    .rxrdy      (ch_rxrdy),
    .mask_we    (wsel.mask),
    .mask_wdata (bus_wdata),
    .status     (status),
    .irq_n      (irq_n)
  );

  duart_io_port #(.PORT_W(P_DATA_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_we  (wsel.opset),
    .clr_we  (wsel.opclr),
    .wdata   (bus_wdata),
    .pins_n  (op_pins_n),
    .ip_pins (ip_pins),
    .ip_sync (ip_sync)
  );

  always_comb begin
    aux_d = aux_q;
    cfg_d = cfg_q;
    if (wsel.aux) aux_d = bus_wdata;
    if (wsel.cfg) cfg_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      aux_q <= '0;
      cfg_q <= '0;
    end else begin
      aux_q <= aux_d;
      cfg_q <= cfg_d;
    end
  end

  assign aux_ctrl = aux_q;
  assign op_cfg   = cfg_q;

  always_comb begin
    case (bus_addr)
      OFS_INT:    bus_rdata = status;
      OFS_INPCFG: bus_rdata = ip_sync;
      default:    bus_rdata = '0;
    endcase
  end

  a_r10_cfg_store: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OFS_INPCFG) |=> (op_cfg == $past(bus_wdata)));
  a_r10_aux_store: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OFS_AUX) |=> (aux_ctrl == $past(bus_wdata)));
  a_r12_aux_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && (bus_addr == OFS_AUX || bus_addr == OFS_INPCFG))
      |=> ($stable(aux_ctrl) && $stable(op_cfg)));
endmodule

// File: tb/duart_shared_regs_tb_top.sv
module duart_shared_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] ch_txrdy, ch_rxrdy;
  logic       irq_n;
  logic [7:0] op_pins_n, ip_pins, aux_ctrl, op_cfg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  duart_shared_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_txrdy(ch_txrdy),
    .ch_rxrdy(ch_rxrdy), .irq_n(irq_n), .op_pins_n(op_pins_n),
    .ip_pins(ip_pins), .aux_ctrl(aux_ctrl), .op_cfg(op_cfg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 6'h00; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 6'h00;
  endtask

  task automatic flags(input logic [1:0] tx, input logic [1:0] rx);
    @(negedge clk);
    ch_txrdy = tx; ch_rxrdy = rx;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 op_pins_n", op_pins_n, 8'hFF);
    check("R1 aux_ctrl", aux_ctrl, 8'h00);
    check("R1 op_cfg", op_cfg, 8'h00);
    rd(6'h14, v); check("R1 status", v, 8'h00);
  endtask

  task automatic t_status_irq();
    logic [7:0] v;
    flags(2'b01, 2'b00);
    rd(6'h14, v); check("R2 A tx bit0", v, 8'h01);
    check("R4 masked off", {7'd0, irq_n}, 8'h01);
    wr(6'h14, 8'h02);
    rd(6'h14, v); check("R3 read after mask write", v, 8'h01);
    check("R4 tx not enabled", {7'd0, irq_n}, 8'h01);
    flags(2'b01, 2'b01);
    rd(6'h14, v); check("R2 A rx bit1", v, 8'h03);
    check("R4 A rx enabled", {7'd0, irq_n}, 8'h00);
    rd(6'h14, v); check("R5 read no clear", v, 8'h03);
    flags(2'b01, 2'b00);
    check("R5 irq drops", {7'd0, irq_n}, 8'h01);
    flags(2'b10, 2'b10);
    rd(6'h14, v); check("R2 B bits 4,5", v, 8'h30);
    check("R11 reserved zero", v & 8'hCC, 8'h00);
    wr(6'h14, 8'h10);
    check("R4 B tx enabled", {7'd0, irq_n}, 8'h00);
    wr(6'h14, 8'h00);
    check("R4 mask cleared", {7'd0, irq_n}, 8'h01);
    wr(6'h14, 8'h20);
    check("R4 B rx enabled", {7'd0, irq_n}, 8'h00);
    flags(2'b00, 2'b00);
    rd(6'h14, v); check("R5 all clear", v, 8'h00);
    check("R5 irq off", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_out_port();
    wr(6'h38, 8'h05); check("R6 set", op_pins_n, 8'hFA);
    wr(6'h38, 8'h30); check("R6 set merge", op_pins_n, 8'hCA);
    wr(6'h3C, 8'h04); check("R7 clear one", op_pins_n, 8'hCE);
    wr(6'h3C, 8'h00); check("R7 clear none", op_pins_n, 8'hCE);
    wr(6'h3C, 8'hFF); check("R8 all idle", op_pins_n, 8'hFF);
    wr(6'h38, 8'h81);
  endtask

  task automatic t_cfg_aux();
    wr(6'h34, 8'hA5);
    check("R10 op_cfg", op_cfg, 8'hA5);
    check("R10 pins kept", op_pins_n, 8'h7E);
    wr(6'h10, 8'h80);
    check("R10 aux_ctrl", aux_ctrl, 8'h80);
    check("R10 cfg kept", op_cfg, 8'hA5);
  endtask

  task automatic t_inport();
    logic [7:0] v;
    @(negedge clk); ip_pins = 8'h3C;
    @(negedge clk);
    rd(6'h34, v); check("R9 one edge old", v, 8'h00);
    @(negedge clk);
    rd(6'h34, v); check("R9 two edges", v, 8'h3C);
    @(negedge clk); ip_pins = 8'hC3;
    @(negedge clk); @(negedge clk);
    rd(6'h34, v); check("R9 second value", v, 8'hC3);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(6'h14, 8'h01);
    flags(2'b01, 2'b00);
    wr(6'h00, 8'hFF);
    wr(6'h20, 8'h00);
    wr(6'h3F, 8'hFF);
    check("R12 pins", op_pins_n, 8'h7E);
    check("R12 aux", aux_ctrl, 8'h80);
    check("R12 cfg", op_cfg, 8'hA5);
    check("R12 mask kept", {7'd0, irq_n}, 8'h00);
    rd(6'h00, v); check("R11 unmapped read", v, 8'h00);
    rd(6'h38, v); check("R11 write-only read", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ch_txrdy = '0; ch_rxrdy = '0; ip_pins = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_status_irq();
    t_out_port();
    t_cfg_aux();
    t_inport();
    t_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule